// File: doc/BRIEF.md
# Dual-Write Register File with Base Auto-Increment

This block is a 32-entry, 32-bit general register file for a single-cycle processor datapath. It has two read ports that are combinational and two write ports that update on the rising clock edge. The first write port is conventional, with its own address, data and enable. The second write port has no address of its own. It always targets the register selected by read port A. The value it writes is that register's current contents plus a fixed step of 4, formed by an internal adder.

With both ports, a load that post-increments its base register can finish in one clock. Port 1 writes the loaded word to the destination register. Port 2 advances the base register named on read port A. Register 0 is hard-wired to zero. When both ports aim at the same register in the same cycle, port 1 wins. A synchronous reset clears all registers.

Top module: `rf_dual_wr`

## Requirements
- R1: With `rst` high at a rising edge, every register reads zero after that edge.
- R2: Both read ports are combinational: `rd_a_data` and `rd_b_data` show the current contents of the addressed register in the same cycle, with no clock in between.
- R3: When `wr_en` is high at a rising edge, register `wr_addr` holds `wr_data` after that edge.
- R4: When `bump_en` is high at a rising edge, the register selected by `rd_a_addr` holds its pre-edge value plus 4 after that edge.
- R5: Port 1 and port 2 can update two different registers on the same edge.
- R6: Register 0 always reads 0 on both ports, and writes to it from either port are discarded.
- R7: If `wr_en` and `bump_en` are both high and `wr_addr` equals `rd_a_addr`, that register takes `wr_data` and the increment is dropped.
- R8: A read of a register being written in the same cycle returns the old value until the edge.
- R9: The increment wraps modulo 2^32, so 0xFFFFFFFC becomes 0x00000000.
- R10: With `wr_en` and `bump_en` low, an edge changes no register, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Read port A address; also the port 2 write target |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B address |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Port 1 write enable |
| wr_addr | input | 5 | Port 1 write address |
| wr_data | input | 32 | Port 1 write data |
| bump_en | input | 1 | Port 2 enable: add 4 to the register on read port A |

## Verification
Reads are combinational, so a wrong register value shows on a read port in the first cycle after the faulty edge, as soon as that register is addressed. A priority fault, a dropped increment, or a wrong step is visible one edge after the write that caused it. A stray write that hits an unrelated register stays hidden until that register is read. For that reason the tests read back the registers next to each one they write.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Which write port, if any, updates a given register on the next edge.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_BUMP = 2'd2
  } wsrc_e;
endpackage

// File: rtl/rf_bump.sv
module rf_bump #(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic [DATA_W-1:0] base_i,
  output logic [DATA_W-1:0] next_o
);
  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v);
    return v + DATA_W'(STEP);
  endfunction

  assign next_o = advance(base_i);
endmodule

// File: rtl/rf_wr_arbiter.sv
module rf_wr_arbiter
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              bump_en,
  input  logic [ADDR_W-1:0] bump_addr,
  output logic              load_live,
  output logic              bump_live,
  output wsrc_e             src [NUM_REGS]
);
  // Register 0 is never a write target; port 1 beats port 2 on a clash.
  assign load_live = wr_en && (wr_addr != '0);
  assign bump_live = bump_en && (bump_addr != '0) &&
                     !(load_live && (wr_addr == bump_addr));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    always_comb begin
      if (load_live && (wr_addr == ADDR_W'(i)))        src[i] = SRC_LOAD;
      else if (bump_live && (bump_addr == ADDR_W'(i))) src[i] = SRC_BUMP;
      else                                             src[i] = SRC_NONE;
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  wsrc_e             src [NUM_REGS],
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] bump_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [NUM_REGS-1:0][DATA_W-1:0] cells;

  // Entry 0 is a constant; the others are storage cells.
  assign cells[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else begin
        case (src[i])
          SRC_LOAD: q <= load_data;
          SRC_BUMP: q <= bump_data;
          default:  q <= q;
        endcase
      end
    end
    assign cells[i] = q;
  end

  // Combinational reads: a same-cycle write is seen only after the edge.
  assign rd_a_data = cells[rd_a_addr];
  assign rd_b_data = cells[rd_b_addr];
endmodule

// File: rtl/rf_dual_wr.sv
module rf_dual_wr
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int STEP     = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bump_en
);
  // Named internal events for the checker.
  logic              load_live;
  logic              bump_live;
  logic [DATA_W-1:0] bump_val;
  wsrc_e             src [NUM_REGS];

  rf_bump #(.DATA_W(DATA_W), .STEP(STEP)) u_bump (
    .base_i (rd_a_data),
    .next_o (bump_val)
  );

  rf_wr_arbiter #(.NUM_REGS(NUM_REGS)) u_arb (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .bump_en   (bump_en),
    .bump_addr (rd_a_addr),
    .load_live (load_live),
    .bump_live (bump_live),
    .src       (src)
  );

  rf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .load_data (wr_data),
    .bump_data (bump_val),
    .rd_a_addr (rd_a_addr),
    .rd_b_addr (rd_b_addr),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );
endmodule

// File: rtl/rf_dual_wr_chk.sv
module rf_dual_wr_chk #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int STEP     = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              bump_en,
  input logic              load_live,
  input logic              bump_live
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0)); // R1

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == '0) |-> (rd_a_data == '0)); // R6

  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == '0) |-> (rd_b_data == '0)); // R6

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      (rd_b_addr != $past(wr_addr) || rd_b_data == $past(wr_data))); // R3

  AST_BUMP_LANDS: assert property (@(posedge clk) disable iff (rst)
    (bump_en && rd_a_addr != '0 && !(wr_en && wr_addr == rd_a_addr)) |=>
      (rd_b_addr != $past(rd_a_addr) ||
       rd_b_data == $past(rd_a_data) + DATA_W'(STEP))); // R4

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (load_live && bump_live) |-> (wr_addr != rd_a_addr)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !bump_en) |=>
      (rd_b_addr != $past(rd_b_addr) || $stable(rd_b_data))); // R10
endmodule

bind rf_dual_wr rf_dual_wr_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .STEP(STEP)
) u_chk (
  .clk(clk), .rst(rst),
  .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
  .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .bump_en(bump_en), .load_live(load_live), .bump_live(bump_live)
);

// File: tb/sim_rf_dual_wr.sv
`timescale 1ns/1ps
module sim_rf_dual_wr;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, bump_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rf_dual_wr u0 (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bump_en(bump_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    wr_en = 1'b0; bump_en = 1'b0;
  endtask

  task automatic put(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; bump_en = 1'b0;
    tick();
    quiet();
  endtask

  task automatic bump(input logic [4:0] a);
    rd_a_addr = a; bump_en = 1'b1; wr_en = 1'b0;
    tick();
    quiet();
  endtask

  task automatic peek(input string req, input logic [4:0] a, input logic [31:0] exp);
    rd_b_addr = a; #0.5;
    chk(req, rd_b_data, exp);
  endtask

  task automatic t_reset();
    peek("R1 r0 after reset", 5'd0, 32'h0);
    peek("R1 r5 after reset", 5'd5, 32'h0);
    peek("R1 r31 after reset", 5'd31, 32'h0);
    put(5'd12, 32'hDEAD_BEEF);
    rst = 1'b1; tick(); rst = 1'b0;
    peek("R1 r12 cleared by reset", 5'd12, 32'h0);
  endtask

  task automatic t_write();
    put(5'd3, 32'h1234_5678);
    put(5'd17, 32'hCAFE_0001);
    put(5'd31, 32'h8000_0000);
    peek("R3 r3", 5'd3, 32'h1234_5678);
    peek("R3 r17", 5'd17, 32'hCAFE_0001);
    peek("R3 r31", 5'd31, 32'h8000_0000);
    peek("R3 neighbour r4 untouched", 5'd4, 32'h0);
    rd_a_addr = 5'd17; #0.5;
    chk("R2 port A same-cycle read", rd_a_data, 32'hCAFE_0001);
    rd_a_addr = 5'd3; #0.5;
    chk("R2 port A re-address", rd_a_data, 32'h1234_5678);
  endtask

  task automatic t_bump();
    put(5'd4, 32'd100);
    bump(5'd4);
    peek("R4 r4 +4", 5'd4, 32'd104);
    bump(5'd4);
    peek("R4 r4 +8", 5'd4, 32'd108);
    peek("R4 r3 untouched", 5'd3, 32'h1234_5678);
  endtask

  task automatic t_dual();
    put(5'd4, 32'd200);
    rd_a_addr = 5'd4; bump_en = 1'b1;
    wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h0BAD_F00D;
    tick(); quiet();
    peek("R5 base r4 advanced", 5'd4, 32'd204);
    peek("R5 dest r9 loaded", 5'd9, 32'h0BAD_F00D);
  endtask

  task automatic t_conflict();
    put(5'd6, 32'd50);
    rd_a_addr = 5'd6; bump_en = 1'b1;
    wr_en = 1'b1; wr_addr = 5'd6; wr_data = 32'h0000_AAAA;
    tick(); quiet();
    peek("R7 load wins on clash", 5'd6, 32'h0000_AAAA);
  endtask

  task automatic t_zero();
    put(5'd0, 32'hFFFF_FFFF);
    peek("R6 r0 after write", 5'd0, 32'h0);
    bump(5'd0);
    peek("R6 r0 after bump", 5'd0, 32'h0);
    rd_a_addr = 5'd0; #0.5;
    chk("R6 r0 on port A", rd_a_data, 32'h0);
    peek("R6 r1 not hit", 5'd1, 32'h0);
  endtask

  task automatic t_rdw();
    put(5'd8, 32'd11);
    wr_en = 1'b1; wr_addr = 5'd8; wr_data = 32'd22;
    rd_b_addr = 5'd8; #0.5;
    chk("R8 old value before edge", rd_b_data, 32'd11);
    tick(); quiet();
    peek("R8 new value after edge", 5'd8, 32'd22);
    rd_a_addr = 5'd8; bump_en = 1'b1; rd_b_addr = 5'd8; #0.5;
    chk("R8 old value during bump", rd_b_data, 32'd22);
    tick(); quiet();
    peek("R8 bumped after edge", 5'd8, 32'd26);
  endtask

  task automatic t_wrap();
    put(5'd10, 32'hFFFF_FFFC);
    bump(5'd10);
    peek("R9 wrap to zero", 5'd10, 32'h0);
    put(5'd11, 32'hFFFF_FFFE);
    bump(5'd11);
    peek("R9 wrap to two", 5'd11, 32'h0000_0002);
  endtask

  task automatic t_idle();
    put(5'd3, 32'h5555_0003);
    wr_en = 1'b0; wr_addr = 5'd3; wr_data = 32'h9999_9999;
    bump_en = 1'b0; rd_a_addr = 5'd3;
    tick(); tick();
    peek("R10 disabled ports leave r3", 5'd3, 32'h5555_0003);
  endtask

  initial begin
    rst = 1'b1; quiet();
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_write();
    t_bump();
    t_dual();
    t_conflict();
    t_zero();
    t_rdw();
    t_wrap();
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule